// File: doc/BRIEF.md
# Day/Time Counter with Alarm

This block keeps calendar-free time of day as four fields: seconds, minutes, hours and a running day count. A slow reference clock reaches it as a one-cycle strobe, `ref_tick`, synchronous to the fast system clock. A runtime-selectable prescaler counts these strobes and produces one seconds step per second of reference time. The counters then ripple seconds into minutes, minutes into hours and hours into the day count.

Software uses a 16-bit register port with a select, a write strobe, a byte offset and write data. It writes and reads the current time, an alarm time in the same packed layout, and a control register. The control register holds an enable bit and a 2-bit reference-frequency select. Reads are combinational and return the live counter values.

When a seconds step moves the time onto the programmed alarm day and time, the block raises `alarm_evt` for a single clock.

Top module: `rtc_daytime`

## Requirements
- R1: After reset, all time, alarm and control registers read 0, and `alarm_evt` is low.
- R2: The control register at offset 0x10 keeps the enable in bit 7 and the reference select in bits 6:5. A written value reads back in those bits, and every other bit reads 0.
- R3: While enabled, select 0, 1 and 2 give one seconds step per DIV_REF0, DIV_REF1 and DIV_REF2 `ref_tick` strobes respectively. The defaults are 32768, 32000 and 38400.
- R4: Select value 3 stops the prescaler. With select 3, strobes neither advance the time nor change the prescaler fraction.
- R5: With the enable bit clear, strobes have no effect on the time. The prescaler fraction is kept and resumes once the block is enabled again.
- R6: Each field wraps to 0 and carries into the next field when it steps from its limit. The limit is 59 for seconds and minutes and 23 for hours. A loaded value above the limit also wraps to 0 with a carry on its next step.
- R7: The day count is 16 bits wide and wraps from its maximum to 0. With SHORT_DAY set it is 9 bits wide and wraps from 511 to 0.
- R8: The register offsets are as follows. Offset 0x00 holds the time with hours in bits 15:8 and minutes in bits 7:0. Offset 0x04 holds seconds in bits 7:0. Offset 0x20 holds the day count. Offsets 0x08, 0x0C and 0x24 hold the alarm in the same three layouts. Unused bits and unmapped offsets read 0, and `bus_rdata` is 0 while `bus_sel` is low.
- R9: A write to a time register loads its field or fields in the next cycle. A write to seconds also restarts the prescaler fraction, so the next step comes a full divide period after the write.
- R10: `alarm_evt` is high for exactly one clock, in the cycle right after the step edge that brings the time to the alarm. A match requires all four alarm fields to be equal. A bus write that makes the time equal to the alarm raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_tick | input | 1 | One-cycle strobe per reference clock period |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Live read data for bus_addr while bus_sel is high |
| alarm_evt | output | 1 | One-cycle alarm event |

## Verification
The single-pulse property assumes that two consecutive seconds steps never land on the alarm. A pulse can repeat only if the time is rewritten between steps. The stimulus therefore loads the time and alarm only while `ref_tick` is low. It uses divide ratios of at least four, so several clocks separate any two steps. The stepping and hold properties are evaluated only in cycles with no bus write, and the stimulus never writes in the same cycle as a strobe.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int FIELD_W = 8;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 16;

  localparam logic [ADDR_W-1:0] OFS_HM   = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_SEC  = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_AHM  = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_ASEC = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_CTL  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_DAY  = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_ADAY = 6'h24;

  localparam int CTL_EN_BIT  = 7;
  localparam int CTL_SEL_LSB = 5;

  typedef enum logic [1:0] {
    REF_A   = 2'd0,
    REF_B   = 2'd1,
    REF_C   = 2'd2,
    REF_OFF = 2'd3
  } ref_sel_e;

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_pkg::*;
#(
  parameter int DIV0 = 32768,
  parameter int DIV1 = 32000,
  parameter int DIV2 = 38400
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  logic     ref_tick,
  input  logic     clr,
  input  ref_sel_e sel,
  output logic     sec_tick
);

  localparam int DMAX = max3(DIV0, DIV1, DIV2);
  localparam int CW   = (DMAX > 1) ? $clog2(DMAX) : 1;

  logic [CW-1:0] frac_q, frac_d, last_sel;
  logic          step, at_end, upd;

  always_comb begin
    unique case (sel)
      REF_A:   last_sel = CW'(DIV0 - 1);
      REF_B:   last_sel = CW'(DIV1 - 1);
      REF_C:   last_sel = CW'(DIV2 - 1);
      default: last_sel = '1;
    endcase
  end

  // The terminal test is >= so a fraction left over from a larger ratio
  // ends on the next strobe after the select changes.
  assign step     = run && ref_tick && (sel != REF_OFF);
  assign at_end   = frac_q >= last_sel;
  assign sec_tick = step && at_end && !clr;
  assign upd      = step || clr;

  always_comb begin
    frac_d = frac_q;
    if (clr)         frac_d = '0;
    else if (at_end) frac_d = '0;
    else             frac_d = frac_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   frac_q <= '0;
    else if (upd) frac_q <= frac_d;
  end

endmodule

// File: rtl/rtc_wrap_ctr.sv
module rtc_wrap_ctr #(
  parameter int W    = 8,
  parameter int LAST = 59
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] val,
  output logic [W-1:0] nxt,
  output logic         carry
);

  localparam logic [W-1:0] LIM = W'(LAST);

  logic [W-1:0] val_q;
  logic         term, upd;

  assign term  = val_q >= LIM;
  assign carry = inc && !ld && term;
  assign upd   = inc || ld;

  // Load has priority over a step in the same cycle.
  always_comb begin
    nxt = val_q;
    if (ld)        nxt = ld_val;
    else if (inc)  nxt = term ? '0 : val_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   val_q <= '0;
    else if (upd) val_q <= nxt;
  end

  assign val = val_q;

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic [FIELD_W-1:0] t_sec,
  input  logic [FIELD_W-1:0] t_min,
  input  logic [FIELD_W-1:0] t_hr,
  input  logic [DW-1:0]      t_day,
  input  logic [FIELD_W-1:0] a_sec,
  input  logic [FIELD_W-1:0] a_min,
  input  logic [FIELD_W-1:0] a_hr,
  input  logic [DW-1:0]      a_day,
  output logic               hit
);

  logic hit_d, hit_q, same;

  assign same  = (t_sec == a_sec) && (t_min == a_min) &&
                 (t_hr == a_hr) && (t_day == a_day);
  assign hit_d = step && same;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_d;
  end

  assign hit = hit_q;

endmodule

// File: rtl/rtc_daytime.sv
module rtc_daytime
  import rtc_pkg::*;
#(
  parameter int DIV_REF0  = 32768,
  parameter int DIV_REF1  = 32000,
  parameter int DIV_REF2  = 38400,
  parameter bit SHORT_DAY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              alarm_evt
);

  localparam int DAY_W     = SHORT_DAY ? 9 : 16;
  localparam int NUM_UNITS = 4;

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // Write decode.
  logic wr_go, wr_hm, wr_sec, wr_day, wr_ahm, wr_asec, wr_aday, wr_ctl;

  assign wr_go   = bus_sel && bus_wr;
  assign wr_hm   = wr_go && (bus_addr == OFS_HM);
  assign wr_sec  = wr_go && (bus_addr == OFS_SEC);
  assign wr_day  = wr_go && (bus_addr == OFS_DAY);
  assign wr_ahm  = wr_go && (bus_addr == OFS_AHM);
  assign wr_asec = wr_go && (bus_addr == OFS_ASEC);
  assign wr_aday = wr_go && (bus_addr == OFS_ADAY);
  assign wr_ctl  = wr_go && (bus_addr == OFS_CTL);

  // Control register.
  logic     ctl_en_q, ctl_en_d;
  ref_sel_e ctl_sel_q, ctl_sel_d;

  always_comb begin
    ctl_en_d  = ctl_en_q;
    ctl_sel_d = ctl_sel_q;
    if (wr_ctl) begin
      ctl_en_d  = bus_wdata[CTL_EN_BIT];
      ctl_sel_d = ref_sel_e'(bus_wdata[CTL_SEL_LSB +: 2]);
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ctl_en_q  <= 1'b0;
      ctl_sel_q <= REF_A;
    end else if (wr_ctl) begin
      ctl_en_q  <= ctl_en_d;
      ctl_sel_q <= ctl_sel_d;
    end
  end

  // Alarm registers.
  logic [FIELD_W-1:0] alm_sec_q, alm_min_q, alm_hr_q;
  logic [FIELD_W-1:0] alm_sec_d, alm_min_d, alm_hr_d;
  logic [DAY_W-1:0]   alm_day_q, alm_day_d;
  logic               alm_upd;

  assign alm_upd = wr_ahm || wr_asec || wr_aday;

  always_comb begin
    alm_sec_d = alm_sec_q;
    alm_min_d = alm_min_q;
    alm_hr_d  = alm_hr_q;
    alm_day_d = alm_day_q;
    if (wr_asec) alm_sec_d = bus_wdata[FIELD_W-1:0];
    if (wr_ahm) begin
      alm_min_d = bus_wdata[FIELD_W-1:0];
      alm_hr_d  = bus_wdata[2*FIELD_W-1:FIELD_W];
    end
    if (wr_aday) alm_day_d = bus_wdata[DAY_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      alm_sec_q <= '0;
      alm_min_q <= '0;
      alm_hr_q  <= '0;
      alm_day_q <= '0;
    end else if (alm_upd) begin
      alm_sec_q <= alm_sec_d;
      alm_min_q <= alm_min_d;
      alm_hr_q  <= alm_hr_d;
      alm_day_q <= alm_day_d;
    end
  end

  // Prescaler.
  logic sec_tick;

  rtc_prescaler #(
    .DIV0 (DIV_REF0),
    .DIV1 (DIV_REF1),
    .DIV2 (DIV_REF2)
  ) i_presc (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .run      (ctl_en_q),
    .ref_tick (ref_tick),
    .clr      (wr_sec),
    .sel      (ctl_sel_q),
    .sec_tick (sec_tick)
  );

  // Counter chain: unit 0 seconds, 1 minutes, 2 hours, 3 days.
  logic [NUM_UNITS:0]   chain;
  logic [NUM_UNITS-1:0] unit_ld;
  logic [FIELD_W-1:0]   sec_val, min_val, hr_val, sec_nxt, min_nxt, hr_nxt;
  logic [DAY_W-1:0]     day_val, day_nxt;
  logic                 day_wrap;

  assign chain[0] = sec_tick;
  assign unit_ld  = {wr_day, wr_hm, wr_hm, wr_sec};
  assign day_wrap = chain[NUM_UNITS];

  for (genvar gi = 0; gi < NUM_UNITS; gi++) begin : g_unit
    localparam int UW    = (gi == NUM_UNITS - 1) ? DAY_W : FIELD_W;
    localparam int ULAST = (gi <= 1) ? 59 : (gi == 2) ? 23 : (2 ** DAY_W) - 1;
    localparam int USH   = (gi == 2) ? FIELD_W : 0;

    logic [UW-1:0] v, n, ldv;

    assign ldv = UW'(bus_wdata >> USH);

    rtc_wrap_ctr #(
      .W    (UW),
      .LAST (ULAST)
    ) i_ctr (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .inc    (chain[gi]),
      .ld     (unit_ld[gi]),
      .ld_val (ldv),
      .val    (v),
      .nxt    (n),
      .carry  (chain[gi+1])
    );

    if (gi == 0) begin : g_sec
      assign sec_val = v;
      assign sec_nxt = n;
    end else if (gi == 1) begin : g_min
      assign min_val = v;
      assign min_nxt = n;
    end else if (gi == 2) begin : g_hr
      assign hr_val = v;
      assign hr_nxt = n;
    end else begin : g_day
      assign day_val = v;
      assign day_nxt = n;
    end
  end

  // Alarm compare on the values the step edge will load.
  rtc_alarm_cmp #(
    .DW (DAY_W)
  ) i_alarm (
    .clk   (clk),
    .rst_n (rst_core_n),
    .step  (sec_tick),
    .t_sec (sec_nxt),
    .t_min (min_nxt),
    .t_hr  (hr_nxt),
    .t_day (day_nxt),
    .a_sec (alm_sec_q),
    .a_min (alm_min_q),
    .a_hr  (alm_hr_q),
    .a_day (alm_day_q),
    .hit   (alarm_evt)
  );

  // Read mux.
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    unique case (bus_addr)
      OFS_HM:   rd_mux = {hr_val, min_val};
      OFS_SEC:  rd_mux = {8'h00, sec_val};
      OFS_AHM:  rd_mux = {alm_hr_q, alm_min_q};
      OFS_ASEC: rd_mux = {8'h00, alm_sec_q};
      OFS_CTL:  rd_mux = {8'h00, ctl_en_q, ctl_sel_q, 5'b00000};
      OFS_DAY:  rd_mux = DATA_W'(day_val);
      OFS_ADAY: rd_mux = DATA_W'(alm_day_q);
      default:  rd_mux = '0;
    endcase
  end

  assign bus_rdata = bus_sel ? rd_mux : '0;

endmodule

// File: rtl/rtc_daytime_chk.sv
module rtc_daytime_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [5:0]    bus_addr,
  input logic          ctl_wbit,
  input logic          alarm_evt,
  input logic          ctl_en,
  input logic [1:0]    ctl_sel,
  input logic [7:0]    sec_q,
  input logic [7:0]    min_q,
  input logic [7:0]    hr_q,
  input logic [DW-1:0] day_q,
  input logic [7:0]    alm_sec,
  input logic [7:0]    alm_min,
  input logic [7:0]    alm_hr,
  input logic [DW-1:0] alm_day,
  input logic          day_wrap
);

  logic any_wr, ctl_wr;
  assign any_wr = bus_sel && bus_wr;
  assign ctl_wr = any_wr && (bus_addr == 6'h10);

  p_ctl_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (ctl_en == $past(ctl_wbit)));

  p_sel_off_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_sel == 2'd3 && !any_wr) |=> $stable(sec_q));

  p_off_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en && !any_wr) |=> ($stable(sec_q) && $stable(min_q) &&
                              $stable(hr_q) && $stable(day_q)));

  p_sec_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !any_wr |=> (sec_q == $past(sec_q) || sec_q == $past(sec_q) + 8'd1 ||
                 sec_q == 8'd0));

  p_day_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (day_wrap && !any_wr) |=> (day_q == '0));

  p_alarm_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_evt && !$past(any_wr)) |-> (sec_q == alm_sec && min_q == alm_min &&
                                       hr_q == alm_hr && day_q == alm_day));

  p_alarm_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |=> !alarm_evt);

endmodule

bind rtc_daytime rtc_daytime_chk #(.DW(DAY_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .ctl_wbit  (bus_wdata[7]),
  .alarm_evt (alarm_evt),
  .ctl_en    (ctl_en_q),
  .ctl_sel   (ctl_sel_q),
  .sec_q     (sec_val),
  .min_q     (min_val),
  .hr_q      (hr_val),
  .day_q     (day_val),
  .alm_sec   (alm_sec_q),
  .alm_min   (alm_min_q),
  .alm_hr    (alm_hr_q),
  .alm_day   (alm_day_q),
  .day_wrap  (day_wrap)
);

// File: tb/test_rtc_daytime.sv
`timescale 1ns/1ps
module test_rtc_daytime;

  localparam int D0 = 4;
  localparam int D1 = 5;
  localparam int D2 = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ref_tick;
  logic        bus_sel;
  logic        bus_wr;
  logic [5:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        alarm_evt;

  int checks = 0;
  int fails  = 0;
  int alarm_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_daytime #(
    .DIV_REF0  (D0),
    .DIV_REF1  (D1),
    .DIV_REF2  (D2),
    .SHORT_DAY (1'b1)
  ) i_rtc_daytime (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_tick  (ref_tick),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .alarm_evt (alarm_evt)
  );

  always @(negedge clk) if (alarm_evt) alarm_cnt++;

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic expect_reg(input string tag, input logic [5:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  // Holds ref_tick high across exactly n rising edges.
  task automatic ref_run(input int n);
    @(negedge clk);
    ref_tick = 1'b1;
    repeat (n) @(negedge clk);
    ref_tick = 1'b0;
  endtask

  task automatic t_reset;
    expect_reg("R1 hm", 6'h00, 16'h0000);
    expect_reg("R1 sec", 6'h04, 16'h0000);
    expect_reg("R1 day", 6'h20, 16'h0000);
    expect_reg("R1 alarm hm", 6'h08, 16'h0000);
    expect_reg("R1 alarm sec", 6'h0C, 16'h0000);
    expect_reg("R1 alarm day", 6'h24, 16'h0000);
    expect_reg("R1 ctl", 6'h10, 16'h0000);
    check("R1 alarm_evt", {15'd0, alarm_evt}, 16'h0000);
  endtask

  task automatic t_ctl;
    wr(6'h10, 16'hFFFF);
    expect_reg("R2 ctl all ones", 6'h10, 16'h00E0);
    wr(6'h10, 16'h0040);
    expect_reg("R2 ctl select 2", 6'h10, 16'h0040);
    wr(6'h10, 16'h0000);
  endtask

  task automatic t_map;
    wr(6'h00, 16'h1234);
    expect_reg("R8 hm", 6'h00, 16'h1234);
    wr(6'h04, 16'hAB2A);
    expect_reg("R8 sec", 6'h04, 16'h002A);
    wr(6'h20, 16'hFFFF);
    expect_reg("R8 day 9 bit", 6'h20, 16'h01FF);
    wr(6'h08, 16'h0A0B);
    expect_reg("R8 alarm hm", 6'h08, 16'h0A0B);
    wr(6'h0C, 16'h1239);
    expect_reg("R8 alarm sec", 6'h0C, 16'h0039);
    wr(6'h24, 16'h0303);
    expect_reg("R8 alarm day", 6'h24, 16'h0103);
    expect_reg("R8 unmapped", 6'h14, 16'h0000);
    @(negedge clk);
    bus_addr = 6'h00;
    #1 check("R8 no select", bus_rdata, 16'h0000);
  endtask

  task automatic t_ratio;
    for (int s = 0; s < 3; s++) begin
      int r;
      r = (s == 0) ? D0 : (s == 1) ? D1 : D2;
      wr(6'h10, 16'h0080 | 16'(s << 5));
      wr(6'h04, 16'h0000);
      ref_run(r - 1);
      expect_reg("R3 before period", 6'h04, 16'h0000);
      ref_run(1);
      expect_reg("R3 after period", 6'h04, 16'h0001);
    end
  endtask

  task automatic t_sel_off;
    wr(6'h10, 16'h00E0);
    wr(6'h04, 16'h0010);
    ref_run(20);
    expect_reg("R4 select 3 holds", 6'h04, 16'h0010);
    wr(6'h10, 16'h0080);
    ref_run(D0);
    expect_reg("R4 fraction untouched", 6'h04, 16'h0011);
  endtask

  task automatic t_disable;
    wr(6'h10, 16'h0080);
    wr(6'h04, 16'h0000);
    ref_run(2);
    wr(6'h10, 16'h0000);
    ref_run(10);
    expect_reg("R5 disabled holds", 6'h04, 16'h0000);
    wr(6'h10, 16'h0080);
    ref_run(2);
    expect_reg("R5 fraction kept", 6'h04, 16'h0001);
  endtask

  task automatic t_carry;
    wr(6'h10, 16'h0080);
    wr(6'h20, 16'h0005);
    wr(6'h00, 16'h173B);
    wr(6'h04, 16'h003B);
    ref_run(D0);
    expect_reg("R6 full carry sec", 6'h04, 16'h0000);
    expect_reg("R6 full carry hm", 6'h00, 16'h0000);
    expect_reg("R6 full carry day", 6'h20, 16'h0006);
    wr(6'h00, 16'h0A3B);
    wr(6'h04, 16'h003B);
    ref_run(D0);
    expect_reg("R6 minute carry", 6'h00, 16'h0B00);
    wr(6'h00, 16'h0203);
    wr(6'h04, 16'h0050);
    ref_run(D0);
    expect_reg("R6 sec over limit", 6'h04, 16'h0000);
    expect_reg("R6 sec over limit carry", 6'h00, 16'h0204);
    wr(6'h20, 16'h0007);
    wr(6'h00, 16'h1E3B);
    wr(6'h04, 16'h003B);
    ref_run(D0);
    expect_reg("R6 hour over limit", 6'h00, 16'h0000);
    expect_reg("R6 hour over limit day", 6'h20, 16'h0008);
  endtask

  task automatic t_day_wrap;
    wr(6'h20, 16'h01FF);
    wr(6'h00, 16'h173B);
    wr(6'h04, 16'h003B);
    ref_run(D0);
    expect_reg("R7 day wraps", 6'h20, 16'h0000);
    expect_reg("R7 time wraps", 6'h00, 16'h0000);
  endtask

  task automatic t_load;
    wr(6'h10, 16'h0080);
    wr(6'h04, 16'h0005);
    ref_run(D0 - 1);
    expect_reg("R9 load", 6'h04, 16'h0005);
    wr(6'h04, 16'h0020);
    ref_run(D0 - 1);
    expect_reg("R9 fraction restarted", 6'h04, 16'h0020);
    ref_run(1);
    expect_reg("R9 full period", 6'h04, 16'h0021);
  endtask

  task automatic t_alarm;
    logic [15:0] v;
    wr(6'h10, 16'h0080);
    wr(6'h24, 16'h0002);
    wr(6'h08, 16'h0102);
    wr(6'h0C, 16'h0005);
    wr(6'h20, 16'h0002);
    wr(6'h00, 16'h0102);
    wr(6'h04, 16'h0003);
    alarm_cnt = 0;
    ref_run(D0);
    rd(6'h04, v);
    check("R10 no early event", 16'(alarm_cnt), 16'd0);
    ref_run(D0);
    #1 check("R10 event after step", {15'd0, alarm_evt}, 16'h0001);
    rd(6'h04, v);
    check("R10 matched sec", v, 16'h0005);
    check("R10 event low next cycle", {15'd0, alarm_evt}, 16'h0000);
    ref_run(D0);
    rd(6'h04, v);
    check("R10 single pulse", 16'(alarm_cnt), 16'd1);
    wr(6'h04, 16'h0005);
    repeat (5) @(negedge clk);
    check("R10 no event on write", 16'(alarm_cnt), 16'd1);
    wr(6'h24, 16'h0003);
    wr(6'h04, 16'h0004);
    ref_run(D0);
    rd(6'h04, v);
    check("R10 day mismatch", 16'(alarm_cnt), 16'd1);
  endtask

  initial begin
    rst_n = 1'b0; ref_tick = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ctl();
    t_map();
    t_ratio();
    t_sel_off();
    t_disable();
    t_carry();
    t_day_wrap();
    t_load();
    t_alarm();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule